// File: doc/BRIEF.md
# Display Interrupt Aggregation Controller

This block gathers interrupt events from two display pipes and two non-display sources, and presents them to software as a small set of memory-mapped registers. It drives a single interrupt line. Each pipe keeps a status word with sticky event bits and matching enable bits. The enabled status bits of a pipe are OR-ed together, and only a rising edge of that OR reaches the top level. A level that stays high raises no further event. The top-level sources also include a command-stream user event and a firmware notification event. These strobes arrive as one-cycle pulses.

At the top level a raw status view shows the source pulses as they happen. A mask register decides which pulses are latched into the identity register, and an enable register decides which latched bits drive the interrupt line. Both the identity bits and the pipe status bits are cleared by writing one to them. Software clears the pipe status before it clears the identity register. An edge that arrives while its source is masked is lost for good: it does not appear when the mask is later cleared. Pipe B also carries a backlight event bit, which reaches the top level through the pipe B event path.

Top module: `dint_ctrl`

Register word offsets: 0 = pipe A status, 1 = pipe B status, 2 = raw status (read-only), 3 = mask, 4 = enable, 5 = identity, 6 = status-to-memory mask (plain storage). Every other offset is unmapped. Top-level source bits: bit 0 = user event, bit 1 = firmware event, bit 2 = pipe A event, bit 3 = pipe B event. Pipe status word: bit 0 = vblank-start status, bit 1 = vblank status, bit 2 = backlight status (pipe B only); bits 8, 9 and 10 are the enables for those three status bits.

## Requirements
- R1: After reset the mask register reads 0x000F, the enable register reads 0, the identity register reads 0, both pipe status words read 0, the status-to-memory mask reads 0xFFFF and irq is low.
- R2: A pipe status bit (bits 0..2) is set by its event strobe whether or not its enable bit is set. Writing 1 to a status bit clears it, so writing back the value just read clears every set bit. The enable bits (8..10) read back as written.
- R3: The raw status bit of a pipe (bit 2 for pipe A, bit 3 for pipe B) is high for exactly one cycle, in the cycle after a status bit is set that takes the OR of that pipe's enabled status bits from 0 to 1. While the OR stays high, a further event gives no new pulse.
- R4: An identity bit is set in the cycle after its raw bit is high, but only if the mask bit of that source is 0 in that cycle. A pulse that arrives while the source is masked never sets the bit, even after the mask is later cleared.
- R5: Writing 1 to an identity bit clears it. If a set and a clear reach the same identity bit or pipe status bit in one cycle, the bit ends up set.
- R6: irq is high exactly while some identity bit and its enable bit are both 1. It falls on the clock edge of the write that clears the last such bit, or the write that clears its enable.
- R7: The pipe B status word holds the backlight status bit (bit 2) and its enable (bit 10), and this bit feeds the pipe B event. On pipe A both bit positions always read 0.
- R8: Reads have no side effects: two reads in a row return the same value. An unmapped offset reads 0.
- R9: A user strobe or a firmware strobe shows in raw bits 0 and 1 in the same cycle, and is latched into the identity register when unmasked.
- R10: After a pipe's status and identity bits are cleared, a new event on that pipe sets the identity bit and raises irq again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | AW (4) | Register word offset |
| reg_wdata | input | DW (16) | Write data |
| reg_rdata | output | DW (16) | Read data for reg_addr, available in the same cycle |
| ev_vbl_start | input | 2 | Vblank-start strobe, one bit per pipe |
| ev_vbl | input | 2 | Vblank strobe, one bit per pipe |
| ev_user | input | 1 | Command-stream user event strobe |
| ev_fw | input | 1 | Firmware notification strobe |
| ev_blc | input | 1 | Backlight event strobe (pipe B) |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume the following about the inputs:
- Every event strobe is synchronous to clk.
- The register port makes at most one write per cycle, with a stable address and data.

No data flows through a valid/ready channel, so back-pressure never arises. The bench drives all strobes and writes on the falling edge, so they are sampled cleanly on the next rising edge. Same-cycle collisions between a set and a clear are created on purpose, and only where set priority is under test. The random phase keeps the pipe enables off, so only the user and firmware sources move, with random mask and clear patterns.

// File: rtl/dint_pkg.sv
package dint_pkg;
  // top-level source bit positions (software decodes these)
  localparam int unsigned NSRC      = 4;
  localparam int unsigned SRC_USER  = 0;
  localparam int unsigned SRC_FW    = 1;
  localparam int unsigned SRC_PIPEA = 2;
  localparam int unsigned SRC_PIPEB = 3;
  localparam int unsigned NPIPE     = 2;

  // pipe status word layout
  localparam int unsigned NSTAT  = 3;
  localparam int unsigned ST_VBS = 0;
  localparam int unsigned ST_VBL = 1;
  localparam int unsigned ST_BLC = 2;
  localparam int unsigned EN_OFS = 8;

  // register word offsets
  localparam int unsigned OFS_PSTAT_A = 0;
  localparam int unsigned OFS_PSTAT_B = 1;
  localparam int unsigned OFS_RAW     = 2;
  localparam int unsigned OFS_MASK    = 3;
  localparam int unsigned OFS_ENABLE  = 4;
  localparam int unsigned OFS_IDENT   = 5;
  localparam int unsigned OFS_STMEM   = 6;
endpackage

// File: rtl/dint_edge.sv
module dint_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign pulse = lvl & ~prev;
endmodule

// File: rtl/dint_pipe_stat.sv
module dint_pipe_stat
  import dint_pkg::*;
#(
  parameter bit HAS_BLC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] ev,
  input  logic             wr_sel,
  input  logic [NSTAT-1:0] wr_clr,
  input  logic [NSTAT-1:0] wr_en,
  output logic [NSTAT-1:0] status,
  output logic [NSTAT-1:0] enable,
  output logic             evt_pulse
);
  localparam logic [NSTAT-1:0] IMPL = HAS_BLC ? 3'b111 : 3'b011;

  logic [NSTAT-1:0] clr;
  logic             or_lvl;

  assign clr = wr_sel ? wr_clr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      // set wins over a same-cycle clear
      status <= ((status & ~clr) | ev) & IMPL;
      if (wr_sel) enable <= wr_en & IMPL;
    end
  end

  assign or_lvl = |(status & enable);

  dint_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (or_lvl),
    .pulse (evt_pulse)
  );
endmodule

// File: rtl/dint_ident.sv
module dint_ident
  import dint_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic            mask_wr,
  input  logic            ier_wr,
  input  logic            iir_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] ier,
  output logic [NSRC-1:0] iir,
  output logic            irq
);
  logic [NSRC-1:0] iir_clr;
  logic [NSRC-1:0] iir_set;

  assign iir_clr = iir_wr ? wbits : '0;
  assign iir_set = raw & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      ier  <= '0;
      iir  <= '0;
    end else begin
      if (mask_wr) mask <= wbits;
      if (ier_wr)  ier  <= wbits;
      iir <= (iir & ~iir_clr) | iir_set;
    end
  end

  assign irq = |(iir & ier);
endmodule

// File: rtl/dint_ctrl.sv
module dint_ctrl
  import dint_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPIPE-1:0] ev_vbl_start,
  input  logic [NPIPE-1:0] ev_vbl,
  input  logic             ev_user,
  input  logic             ev_fw,
  input  logic             ev_blc,
  output logic             irq
);
  logic [NPIPE-1:0][NSTAT-1:0] pst;
  logic [NPIPE-1:0][NSTAT-1:0] pen;
  logic [NPIPE-1:0]            ppulse;
  logic [NSRC-1:0]             raw;
  logic [NSRC-1:0]             mask;
  logic [NSRC-1:0]             ier;
  logic [NSRC-1:0]             iir;
  logic [DW-1:0]               stmem;

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    localparam bit HB = (g == 1);
    logic [NSTAT-1:0] ev;
    logic             sel;
    assign ev[ST_VBS] = ev_vbl_start[g];
    assign ev[ST_VBL] = ev_vbl[g];
    assign ev[ST_BLC] = HB ? ev_blc : 1'b0;
    assign sel = reg_wr && (reg_addr == AW'(OFS_PSTAT_A + g));

    dint_pipe_stat #(.HAS_BLC(HB)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .wr_sel    (sel),
      .wr_clr    (reg_wdata[NSTAT-1:0]),
      .wr_en     (reg_wdata[EN_OFS +: NSTAT]),
      .status    (pst[g]),
      .enable    (pen[g]),
      .evt_pulse (ppulse[g])
    );
  end

  assign raw[SRC_USER]  = ev_user;
  assign raw[SRC_FW]    = ev_fw;
  assign raw[SRC_PIPEA] = ppulse[0];
  assign raw[SRC_PIPEB] = ppulse[1];

  dint_ident u_ident (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (raw),
    .mask_wr (reg_wr && (reg_addr == AW'(OFS_MASK))),
    .ier_wr  (reg_wr && (reg_addr == AW'(OFS_ENABLE))),
    .iir_wr  (reg_wr && (reg_addr == AW'(OFS_IDENT))),
    .wbits   (reg_wdata[NSRC-1:0]),
    .mask    (mask),
    .ier     (ier),
    .iir     (iir),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) stmem <= '1;
    else if (reg_wr && (reg_addr == AW'(OFS_STMEM))) stmem <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_PSTAT_A): begin
        reg_rdata[NSTAT-1:0]       = pst[0];
        reg_rdata[EN_OFS +: NSTAT] = pen[0];
      end
      AW'(OFS_PSTAT_B): begin
        reg_rdata[NSTAT-1:0]       = pst[1];
        reg_rdata[EN_OFS +: NSTAT] = pen[1];
      end
      AW'(OFS_RAW):    reg_rdata[NSRC-1:0] = raw;
      AW'(OFS_MASK):   reg_rdata[NSRC-1:0] = mask;
      AW'(OFS_ENABLE): reg_rdata[NSRC-1:0] = ier;
      AW'(OFS_IDENT):  reg_rdata[NSRC-1:0] = iir;
      AW'(OFS_STMEM):  reg_rdata = stmem;
      default:         reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dint_ctrl_chk.sv
module dint_ctrl_chk
  import dint_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [NPIPE-1:0]            ev_vbl_start,
  input logic                        ev_blc,
  input logic [NPIPE-1:0][NSTAT-1:0] pst,
  input logic [NSRC-1:0]             raw,
  input logic [NSRC-1:0]             mask,
  input logic [NSRC-1:0]             ier,
  input logic [NSRC-1:0]             iir,
  input logic                        irq
);
  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '1 && ier == '0 && iir == '0 && !irq));

  assert_raw_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[SRC_PIPEB:SRC_PIPEA] != 2'b00) |=>
      ((raw[SRC_PIPEB:SRC_PIPEA] & $past(raw[SRC_PIPEB:SRC_PIPEA])) == 2'b00));

  assert_masked_edge_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((iir & ~$past(iir) & ~$past(raw & ~mask)) == '0));

  assert_unmasked_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~mask) != '0) |=> ((iir & $past(raw & ~mask)) == $past(raw & ~mask)));

  assert_set_priority_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vbl_start[0] |=> pst[0][ST_VBS]);

  assert_blc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blc |=> pst[1][ST_BLC]);

  assert_blc_absent_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pst[0][ST_BLC]);

  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((iir & ier) == '0) |-> !irq);
endmodule

bind dint_ctrl dint_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_vbl_start (ev_vbl_start),
  .ev_blc       (ev_blc),
  .pst          (pst),
  .raw          (raw),
  .mask         (mask),
  .ier          (ier),
  .iir          (iir),
  .irq          (irq)
);

// File: tb/sim_dint_ctrl.sv
`timescale 1ns/1ps
module sim_dint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  ev_vbl_start = '0;
  logic [1:0]  ev_vbl = '0;
  logic        ev_user = 1'b0;
  logic        ev_fw = 1'b0;
  logic        ev_blc = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_vbl_start(ev_vbl_start),
    .ev_vbl(ev_vbl), .ev_user(ev_user), .ev_fw(ev_fw), .ev_blc(ev_blc), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // one-cycle strobe: 0=vbs A,1=vbl A,2=blc,3=user,4=fw
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_vbl_start[0] = 1'b1;
      1: ev_vbl[0] = 1'b1;
      2: ev_blc = 1'b1;
      3: ev_user = 1'b1;
      default: ev_fw = 1'b1;
    endcase
    @(negedge clk);
    ev_vbl_start = '0; ev_vbl = '0; ev_blc = 1'b0; ev_user = 1'b0; ev_fw = 1'b0;
  endtask

  function automatic logic [15:0] model_ident(input logic [15:0] cur,
                                              input logic [1:0] ev,
                                              input logic [1:0] m);
    return cur | {14'b0, ev & ~m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2, expi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(4'd0, v); chk("R1 pipeA", v, 16'h0000);
    rd(4'd1, v); chk("R1 pipeB", v, 16'h0000);
    rd(4'd2, v); chk("R1 raw", v, 16'h0000);
    rd(4'd3, v); chk("R1 mask", v, 16'h000F);
    rd(4'd4, v); chk("R1 enable", v, 16'h0000);
    rd(4'd5, v); chk("R1 ident", v, 16'h0000);
    rd(4'd6, v); chk("R1 stmem", v, 16'hFFFF);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    // R2 sticky status, W1C, enable readback
    pulse(0);
    rd(4'd0, v); chk("R2 set without enable", v, 16'h0001);
    wr(4'd0, v);
    rd(4'd0, v); chk("R2 write-back clears", v, 16'h0000);
    wr(4'd0, 16'h0300);
    rd(4'd0, v); chk("R2 enable readback", v, 16'h0300);
    wr(4'd4, 16'h000F);

    // R4 masked edge is lost
    wr(4'd0, 16'h0100);
    pulse(0);
    @(negedge clk);
    rd(4'd5, v); chk("R4 masked edge", v, 16'h0000);
    wr(4'd3, 16'h0000);
    repeat (3) @(negedge clk);
    rd(4'd5, v); chk("R4 lost after unmask", v, 16'h0000);
    chk("R4 irq stays low", {15'b0, irq}, 16'h0000);
    rd(4'd0, v); chk("R2 status kept", v, 16'h0101);

    // R3 raw pulse, R4 capture, R6 irq
    wr(4'd0, 16'h0101);
    rd(4'd0, v); chk("R2 clear keeps enable", v, 16'h0100);
    @(negedge clk); ev_vbl_start[0] = 1'b1;
    @(negedge clk); ev_vbl_start[0] = 1'b0;
    rd(4'd2, v); chk("R3 raw pulse high", v, 16'h0004);
    @(negedge clk);
    rd(4'd2, v); chk("R3 raw pulse one cycle", v, 16'h0000);
    rd(4'd5, v); chk("R4 unmasked capture", v, 16'h0004);
    chk("R6 irq high", {15'b0, irq}, 16'h0001);
    wr(4'd5, 16'h0004);
    chk("R6 irq falls on clear", {15'b0, irq}, 16'h0000);
    rd(4'd5, v); chk("R5 ident W1C", v, 16'h0000);

    // R3 no repeat while OR stays high
    wr(4'd0, 16'h0300);
    pulse(1);
    repeat (2) @(negedge clk);
    rd(4'd5, v); chk("R3 no second edge", v, 16'h0000);
    rd(4'd0, v); chk("R2 both status", v, 16'h0303);

    // R10 clear then new edge
    wr(4'd0, 16'h0303);
    rd(4'd0, v); chk("R10 status cleared", v, 16'h0300);
    pulse(0);
    @(negedge clk);
    rd(4'd5, v); chk("R10 ident again", v, 16'h0004);
    chk("R10 irq again", {15'b0, irq}, 16'h0001);

    // R6 enable gating
    wr(4'd4, 16'h0000);
    chk("R6 enable off", {15'b0, irq}, 16'h0000);
    wr(4'd4, 16'h000F);
    chk("R6 enable on", {15'b0, irq}, 16'h0001);
    wr(4'd0, 16'h0303);
    wr(4'd5, 16'h000F);

    // R5 set priority on identity
    pulse(3);
    rd(4'd5, v); chk("R9 user capture", v, 16'h0001);
    @(negedge clk);
    ev_user = 1'b1; reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 16'h0001;
    @(negedge clk);
    ev_user = 1'b0; reg_wr = 1'b0;
    rd(4'd5, v); chk("R5 ident set wins", v, 16'h0001);
    wr(4'd5, 16'h0001);

    // R5 set priority on pipe status
    @(negedge clk);
    ev_vbl_start[0] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 16'h0301;
    @(negedge clk);
    ev_vbl_start[0] = 1'b0; reg_wr = 1'b0;
    rd(4'd0, v); chk("R5 status set wins", v, 16'h0301);
    wr(4'd0, 16'h0303);
    wr(4'd5, 16'h000F);

    // R7 backlight on pipe B
    wr(4'd1, 16'h0400);
    pulse(2);
    @(negedge clk);
    rd(4'd1, v); chk("R7 pipeB blc status", v, 16'h0404);
    rd(4'd5, v); chk("R7 pipeB event", v, 16'h0008);
    wr(4'd1, 16'h0404);
    rd(4'd1, v); chk("R7 blc W1C", v, 16'h0400);
    wr(4'd5, 16'h0008);
    wr(4'd0, 16'h0704);
    rd(4'd0, v); chk("R7 pipeA no blc", v & 16'h0404, 16'h0000);

    // R8 reads side-effect free, unmapped zero; R9 firmware
    pulse(4);
    rd(4'd5, v); @(negedge clk); rd(4'd5, v2);
    chk("R9 fw capture", v, 16'h0002);
    chk("R8 repeat read", v2, v);
    rd(4'd7, v); chk("R8 unmapped 7", v, 16'h0000);
    rd(4'd15, v); chk("R8 unmapped 15", v, 16'h0000);
    wr(4'd5, 16'h0002);

    // random phase: user/fw only, random mask and clears (R4, R5, R6)
    wr(4'd0, 16'h0007);
    wr(4'd1, 16'h0007);
    wr(4'd5, 16'h000F);
    expi = '0;
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m, e, c;
      m = 2'($urandom);
      e = 2'($urandom);
      c = 2'($urandom);
      wr(4'd3, {12'b0, 2'b11, m});
      @(negedge clk);
      ev_user = e[0]; ev_fw = e[1];
      @(negedge clk);
      ev_user = 1'b0; ev_fw = 1'b0;
      expi = model_ident(expi, e, m);
      rd(4'd5, v); chk("R4 random ident", v, expi);
      chk("R6 random irq", {15'b0, irq}, {15'b0, expi != 16'h0});
      wr(4'd5, {14'b0, c});
      expi = expi & ~{14'b0, c};
      rd(4'd5, v); chk("R5 random clear", v, expi);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule